// File: doc/BRIEF.md
# Multi-Mode Serial Peripheral Bus Master

This block is a single-master SPI controller that talks to a small set of peripherals over one shared serial clock, one outgoing data line, one returning data line and a group of active-low select lines. It owns every select line. At most one of them is low at any time, so two peripherals never drive the shared return line together. The serial clock is produced from the system clock by a power-of-two divider, and the clock polarity, clock phase and bit order are chosen at run time.

The host side has three parts: a configuration port, a transmit word port with a valid/ready handshake, and a receive word output that pulses once per completed word. Each word is from one to the full data width in bits. The host marks the word that ends a frame. Until that word has been shifted, the select line stays low and the controller waits for further words, so one frame can hold any number of words. When a frame ends, the select line goes high and stays high for a full serial clock period before the controller becomes free again.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, every select line is high, sclk is low, busy is low, tx_ready is high and rx_valid is low.
- R2: While no frame is in progress, sclk rests at the configured polarity level (polarity 1 gives high, 0 gives low). sclk returns to that level after every word.
- R3: With phase 0, the peripheral samples on odd sclk edges and data changes on even edges. The first bit is on mosi from the cycle in which the select line falls. With phase 1, data changes on odd edges and the peripheral samples on even edges. The controller samples miso on the edges on which the peripheral samples mosi. Rising edges sample when polarity equals phase, and falling edges sample otherwise.
- R4: The divider code c (0..7) makes each sclk half period 2^c system cycles. The first sclk edge comes 2^(c+1) cycles after the select line falls.
- R5: With lsb-first set, bit 0 of the word leaves first. Otherwise bit len-1 leaves first. For example, lsb-first 0x53 shows 1,1,0,0,1,0,1,0 on mosi, and a return stream of 0x46 sent lsb-first is received as 0x46.
- R6: Each word carries len bits taken from the low end of tx_data. Received bits at and above position len read 0. A len of 0, or a len greater than the data width, is treated as the full data width.
- R7: The select line stays low across consecutive words of a frame. Between words, tx_ready is high and the line is released only after the word presented with tx_last.
- R8: At most one select line is low at any time. The line that goes low is the one whose index equals the configured target.
- R9: busy rises in the cycle after a word is accepted from idle. After the select line rises it stays high for 2^(c+1) system cycles, and busy falls at the end of that time.
- R10: A configuration write while busy is high is ignored. The frame in progress and the sclk rest level afterwards keep the earlier settings.
- R11: When a configuration write and a transmit word arrive together while idle, the configuration is taken and tx_ready is low in that cycle. The word is accepted later and shifted with the new settings.
- R12: rx_valid is high for exactly one cycle per word, after the last sample edge of that word, with rx_data holding the received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_cpol | input | 1 | Clock rest level |
| cfg_cpha | input | 1 | Clock phase: 0 samples on odd edges, 1 on even edges |
| cfg_lsb_first | input | 1 | 1 sends bit 0 first |
| cfg_div_code | input | CODE_W | Divider code c, sclk period 2^(c+1) cycles |
| cfg_len | input | LEN_W | Bits per word |
| cfg_target | input | SEL_W | Index of the select line to drive |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be taken |
| tx_data | input | DATA_W | Transmit word |
| tx_last | input | 1 | Word ends the frame |
| rx_valid | output | 1 | One-cycle pulse for a received word |
| rx_data | output | DATA_W | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripherals |
| miso | input | 1 | Serial data from the selected peripheral |
| cs_n | output | NUM_CS | Active-low select lines |
| busy | output | 1 | A frame or its closing gap is in progress |

## Verification
A configuration write and a transmit word can reach the idle controller in the same cycle. The bench offers both on the same clock edge and expects tx_ready to be low there. It then expects the word to be shifted with the new polarity, phase, bit order and target. A configuration write can also land in the middle of a frame. The bench writes a different polarity, divider and bit order while busy is high and judges the result at the pins: the captured word must keep the old bit order, the edge spacing must keep the old divider, and the clock rest level must keep the old polarity.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_XFER  = 3'd2,
        ST_HOLD  = 3'd3,
        ST_TRAIL = 3'd4,
        ST_GAP   = 3'd5
    } spim_state_e;
endpackage

// File: rtl/spim_tick_gen.sv
module spim_tick_gen #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int CNT_W = (1 << CODE_W) - 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   half;

    assign half = (CNT_W + 1)'(1) << code;
    assign tick = en && !clr && ({1'b0, cnt_q} == half - (CNT_W + 1)'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = tick ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spim_cs_decode.sv
module spim_cs_decode #(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = 2
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              on,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        assign cs_n[g] = !(on && (sel == SEL_W'(g)));
    end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NUM_CS = 4,
    parameter int CODE_W = 3,
    localparam int LEN_W  = $clog2(DATA_W + 1),
    localparam int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic [CODE_W-1:0] cfg_div_code,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [SEL_W-1:0]  cfg_target,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_last,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              busy
);
    localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int EDGE_W = LEN_W + 1;

    typedef struct packed {
        logic              cpol;
        logic              cpha;
        logic              lsb;
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
        logic [SEL_W-1:0]  target;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef struct packed {
        spim_state_e       st;
        cfg_t              cfg;
        logic [DATA_W-1:0] txw;
        logic [DATA_W-1:0] rxw;
        logic [IDX_W-1:0]  idx;
        logic [EDGE_W-1:0] edges;
        logic              last;
        logic              sclk;
        logic              cs_on;
        logic              gap;
        logic              rx_valid;
        logic [DATA_W-1:0] rx_data;
    } regs_t;

    regs_t             q, d;
    logic              tick, tick_en, div_clr, take;
    logic [EDGE_W-1:0] edge_no;
    logic              last_edge, odd_edge, sample_now, advance;
    logic [IDX_W-1:0]  start_idx;
    logic [CFG_W-1:0]  cfg_flat;

    spim_tick_gen #(.CODE_W(CODE_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tick_en),
        .clr  (div_clr),
        .code (q.cfg.code),
        .tick (tick)
    );

    spim_cs_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_dec (
        .sel (q.cfg.target),
        .on  (q.cs_on),
        .cs_n(cs_n)
    );

    assign tx_ready   = ((q.st == ST_IDLE) && !cfg_valid) || (q.st == ST_HOLD);
    assign take       = tx_valid && tx_ready;
    assign tick_en    = (q.st != ST_IDLE) && (q.st != ST_HOLD);
    assign edge_no    = q.edges + EDGE_W'(1);
    assign last_edge  = (edge_no == {q.cfg.len, 1'b0});
    assign odd_edge   = edge_no[0];
    assign sample_now = q.cfg.cpha ? !odd_edge : odd_edge;
    assign advance    = q.cfg.cpha ? (odd_edge && (edge_no != EDGE_W'(1)))
                                   : (!odd_edge && !last_edge);
    assign start_idx  = q.cfg.lsb ? '0 : IDX_W'(q.cfg.len - LEN_W'(1));
    assign div_clr    = take;
    assign cfg_flat   = q.cfg;

    always_comb begin
        d          = q;
        d.rx_valid = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cfg_valid) begin
                    d.cfg.cpol   = cfg_cpol;
                    d.cfg.cpha   = cfg_cpha;
                    d.cfg.lsb    = cfg_lsb_first;
                    d.cfg.code   = cfg_div_code;
                    d.cfg.target = cfg_target;
                    d.cfg.len    = ((cfg_len == '0) || (cfg_len > LEN_W'(DATA_W)))
                                   ? LEN_W'(DATA_W) : cfg_len;
                    d.sclk       = cfg_cpol;
                end
            end
            ST_LEAD: begin
                if (tick) d.st = ST_XFER;
            end
            ST_XFER: begin
                if (tick) begin
                    d.sclk  = !q.sclk;
                    d.edges = edge_no;
                    if (sample_now) d.rxw[q.idx] = miso;
                    if (advance) begin
                        d.idx = q.cfg.lsb ? q.idx + IDX_W'(1) : q.idx - IDX_W'(1);
                    end
                    if (last_edge) begin
                        d.rx_valid = 1'b1;
                        d.rx_data  = d.rxw;
                        d.st       = q.last ? ST_TRAIL : ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
            end
            ST_TRAIL: begin
                if (tick) begin
                    d.cs_on = 1'b0;
                    d.gap   = 1'b0;
                    d.st    = ST_GAP;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.gap) d.st = ST_IDLE;
                    else       d.gap = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (take) begin
            d.txw   = tx_data;
            d.rxw   = '0;
            d.idx   = start_idx;
            d.edges = '0;
            d.last  = tx_last;
            d.cs_on = 1'b1;
            d.st    = ST_LEAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.cfg.len <= LEN_W'(DATA_W);
        end else begin
            q <= d;
        end
    end

    assign sclk     = q.sclk;
    assign mosi     = q.cs_on ? q.txw[q.idx] : 1'b0;
    assign busy     = (q.st != ST_IDLE);
    assign rx_valid = q.rx_valid;
    assign rx_data  = q.rx_data;
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
    parameter int NUM_CS = 4,
    parameter int CFG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sclk,
    input logic              busy,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic [CFG_W-1:0]  cfg_snap
);
    assert_cs_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n));

    assert_release_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&cs_n) |=> (&cs_n) && busy);

    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> busy);

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cfg_snap == $past(cfg_snap)));

    assert_sclk_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (sclk != $past(sclk))) |-> !(&cs_n));

    assert_rx_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

bind spi_xfer_master spim_checker #(.NUM_CS(NUM_CS), .CFG_W(CFG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .busy    (busy),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .rx_valid(rx_valid),
    .cfg_snap(cfg_flat)
);

// File: tb/spi_xfer_master_tb.sv
module spi_xfer_master_tb;
    localparam int DW  = 8;
    localparam int NCS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_valid = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
    logic [2:0] cfg_div_code = '0;
    logic [3:0] cfg_len = 4'd8;
    logic [1:0] cfg_target = '0;
    logic tx_valid = 1'b0, tx_last = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic tx_ready, rx_valid, sclk, mosi, busy;
    logic [DW-1:0] rx_data;
    logic [NCS-1:0] cs_n;
    logic miso = 1'b0;

    spi_xfer_master u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_div_code(cfg_div_code),
        .cfg_len(cfg_len), .cfg_target(cfg_target), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid),
        .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // peripheral model state
    logic s_cpol = 0, s_cpha = 0, s_lsb = 0;
    int s_len = 8;
    logic [DW-1:0] tw [4];
    logic [DW-1:0] resp [4];
    logic [DW-1:0] cap [4];
    logic [DW-1:0] rxg [4];
    int s_k = 0, s_s = 0, rx_n = 0, cs_falls = 0, edge_n = 0, onehot_bad = 0;
    int edge_t [4];
    int fall_t = 0, rise_t = 0, busy_fall_t = 0;
    logic first_mosi = 0;
    logic [NCS-1:0] cs_seen = '0, prev_csn = '1;
    logic prev_sclk = 0, prev_busy = 0;

    function automatic int bpos(input int k);
        int b = k % s_len;
        return s_lsb ? b : s_len - 1 - b;
    endfunction

    function automatic logic rbit(input int k);
        return resp[(k / s_len) % 4][bpos(k)];
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (!$onehot0(~cs_n)) onehot_bad++;
            if ((&prev_csn) && !(&cs_n)) begin
                cs_falls++;
                fall_t = cyc; cs_seen = ~cs_n; first_mosi = mosi;
                s_k = 0; s_s = 0; edge_n = 0;
                if (!s_cpha) begin miso = rbit(0); s_k = 1; end
            end else if (!(&cs_n) && (sclk !== prev_sclk)) begin
                if (edge_n < 4) edge_t[edge_n] = cyc;
                edge_n++;
                if ((sclk == 1'b1) == (s_cpol == s_cpha)) begin
                    cap[(s_s / s_len) % 4][bpos(s_s)] = mosi;
                    s_s++;
                end else begin
                    miso = rbit(s_k);
                    s_k++;
                end
            end
            if (!(&prev_csn) && (&cs_n)) rise_t = cyc;
            if (prev_busy && !busy) busy_fall_t = cyc;
            if (rx_valid) begin rxg[rx_n % 4] = rx_data; rx_n++; end
        end
        prev_csn = cs_n; prev_sclk = sclk; prev_busy = busy;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic pol, input logic pha, input logic lsb,
                           input int code, input int len, input int tgt);
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb;
        cfg_div_code = 3'(code); cfg_len = 4'(len); cfg_target = 2'(tgt);
        cfg_valid = 1'b1;
        s_cpol = pol; s_cpha = pha; s_lsb = lsb;
        s_len = (len == 0 || len > DW) ? DW : len;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic push(input logic [DW-1:0] data, input logic last);
        tx_data = data; tx_last = last; tx_valid = 1'b1;
        #1;
        while (!tx_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_obs();
        rx_n = 0; cs_falls = 0; onehot_bad = 0;
        for (int i = 0; i < 4; i++) begin cap[i] = '0; rxg[i] = '0; edge_t[i] = 0; end
    endtask

    task automatic run_frame(input int n, input int code, input int tgt, input string nm);
        int h = 1 << code;
        logic [DW-1:0] mask = DW'((1 << s_len) - 1);
        clear_obs();
        @(negedge clk);
        for (int i = 0; i < n; i++) push(tw[i], i == n - 1);
        wait_idle();
        for (int i = 0; i < n; i++) begin
            chk(cap[i] == (tw[i] & mask), $sformatf("R3 R5 R6 %s mosi word %0d", nm, i), cap[i], tw[i] & mask);
            chk(rxg[i] == (resp[i] & mask), $sformatf("R3 R12 %s rx word %0d", nm, i), rxg[i], resp[i] & mask);
        end
        chk(rx_n == n, {"R12 rx pulses ", nm}, rx_n, n);
        chk(cs_falls == 1, {"R7 select falls ", nm}, cs_falls, 1);
        chk(cs_seen == NCS'(1 << tgt), {"R8 target line ", nm}, cs_seen, 1 << tgt);
        chk(onehot_bad == 0, {"R8 exclusive ", nm}, onehot_bad, 0);
        chk(first_mosi == tw[0][s_lsb ? 0 : s_len - 1], {"R3 first bit at select ", nm},
            first_mosi, tw[0][s_lsb ? 0 : s_len - 1]);
        chk(edge_t[0] - fall_t == 2 * h, {"R4 lead time ", nm}, edge_t[0] - fall_t, 2 * h);
        chk(edge_t[1] - edge_t[0] == h, {"R4 half period ", nm}, edge_t[1] - edge_t[0], h);
        chk(busy_fall_t - rise_t == 2 * h, {"R9 release gap ", nm}, busy_fall_t - rise_t, 2 * h);
        chk(sclk == s_cpol, {"R2 rest level ", nm}, sclk, s_cpol);
    endtask

    task automatic t_reset();
        chk(cs_n == '1, "R1 cs_n", cs_n, 4'hF);
        chk(sclk == 1'b0, "R1 sclk", sclk, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    endtask

    task automatic t_mode0();
        set_cfg(0, 0, 0, 0, 8, 0);
        tw[0] = 8'hA5; resp[0] = 8'h3C;
        run_frame(1, 0, 0, "mode0");
    endtask

    task automatic t_mode1_lsb();
        set_cfg(0, 1, 1, 1, 8, 1);
        tw[0] = 8'h53; resp[0] = 8'h46;
        run_frame(1, 1, 1, "mode1 lsb");
    endtask

    task automatic t_mode2_short();
        set_cfg(1, 0, 0, 2, 5, 2);
        chk(sclk == 1'b1, "R2 rest high after config", sclk, 1);
        tw[0] = 8'hFB; resp[0] = 8'h15;
        run_frame(1, 2, 2, "mode2 len5");
    endtask

    task automatic t_mode3_multi();
        set_cfg(1, 1, 0, 1, 8, 3);
        tw[0] = 8'h12; tw[1] = 8'hE7; tw[2] = 8'h5C;
        resp[0] = 8'h9A; resp[1] = 8'h01; resp[2] = 8'hF0;
        run_frame(3, 1, 3, "mode3 three words");
    endtask

    task automatic t_len_zero();
        set_cfg(0, 0, 1, 0, 0, 0);
        tw[0] = 8'hC3; resp[0] = 8'h81;
        run_frame(1, 0, 0, "len0 full width");
    endtask

    task automatic t_slow();
        set_cfg(0, 1, 0, 7, 2, 1);
        tw[0] = 8'h02; resp[0] = 8'h01;
        run_frame(1, 7, 1, "divide 256");
    endtask

    task automatic t_cfg_busy();
        set_cfg(0, 0, 0, 1, 8, 0);
        tw[0] = 8'h5A; resp[0] = 8'h00;
        clear_obs();
        @(negedge clk);
        push(tw[0], 1'b1);
        @(negedge clk);
        cfg_cpol = 1; cfg_div_code = 3'd0; cfg_lsb_first = 1; cfg_target = 2'd2; cfg_valid = 1;
        @(negedge clk);
        cfg_valid = 0;
        wait_idle();
        chk(cap[0] == 8'h5A, "R10 word keeps old order", cap[0], 8'h5A);
        chk(edge_t[1] - edge_t[0] == 2, "R10 divider kept", edge_t[1] - edge_t[0], 2);
        chk(sclk == 1'b0, "R10 rest level kept", sclk, 0);
        chk(cs_seen == 4'b0001, "R10 target kept", cs_seen, 1);
    endtask

    task automatic t_cfg_and_tx();
        set_cfg(0, 0, 0, 0, 8, 0);
        clear_obs();
        resp[0] = 8'h46;
        @(negedge clk);
        cfg_cpol = 1; cfg_cpha = 1; cfg_lsb_first = 1; cfg_div_code = 3'd0;
        cfg_len = 4'd8; cfg_target = 2'd2; cfg_valid = 1;
        tx_data = 8'h53; tx_last = 1; tx_valid = 1;
        s_cpol = 1; s_cpha = 1; s_lsb = 1; s_len = 8;
        #1;
        chk(tx_ready == 1'b0, "R11 ready low on config cycle", tx_ready, 0);
        @(posedge clk); #1;
        cfg_valid = 0;
        while (!tx_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        tx_valid = 0;
        wait_idle();
        chk(cap[0] == 8'h53, "R11 word sent with new order", cap[0], 8'h53);
        chk(rxg[0] == 8'h46, "R11 R5 received lsb-first", rxg[0], 8'h46);
        chk(cs_seen == 4'b0100, "R11 new target", cs_seen, 4);
        chk(sclk == 1'b1, "R11 new rest level", sclk, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_mode1_lsb();
        t_mode2_short();
        t_mode3_multi();
        t_len_zero();
        t_slow();
        t_cfg_busy();
        t_cfg_and_tx();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule